// File: doc/BRIEF.md
# Hop-Count Query Character Loader

This block places the characters of a query string into the elements of a linear chain of processing elements. There is no shared bus and no per-element write strobe. A feeder takes characters from an upstream queue and gives each one a hop count equal to the distance from the chain head to the element that must hold it. It then launches the tagged character into element 0. Every element looks at the count of the character arriving on its input. If the count is zero, the element keeps the character. Otherwise it passes the character to its neighbour with the count reduced by one, one element per clock.

A load begins with a start pulse that carries the query length and a base element index. The queue supplies the characters in order. The first character accepted goes to the highest element of the window, and each later one lands one element lower. A query shorter than the chain can therefore fill the far end of the chain or any window inside it. Each element exposes its stored character and a flag that says whether it holds a query character. A done pulse marks the moment every character of the load has been stored. A clear input erases all stored characters and anything in flight before a fresh load.

The character input is a valid/ready stream. A transfer happens on a clock edge where both valid and ready are high. Ready is high only while a load is active and characters of that load remain to be taken. Holding valid low stalls the load with no loss. A character offered while ready is low is not consumed and stays with the source.

Top module: `ttlq_distributor`

## Requirements
- R1: After reset, every element flag is 0, and in_ready, busy and load_done are all 0.
- R2: A start pulse while idle, with 1 <= qlen <= N_ELEM and base + qlen <= N_ELEM, begins a load. From the next cycle busy is 1 and in_ready is 1 until qlen characters have been accepted.
- R3: The j-th character accepted in a load (j counted from 0) is stored in element base + qlen - 1 - j, and that element's flag becomes 1.
- R4: A character transfers only on an edge with in_valid and in_ready both high. Cycles with in_valid low lose nothing. Once qlen characters have been taken, in_ready is 0 and any further offered character is not stored.
- R5: A character accepted at clock edge t becomes visible in element k right after edge t+1+k, and not before.
- R6: load_done is a one-cycle pulse. It is raised after the last character of the load has been stored, with busy already 0 in that cycle. It never appears twice in a row.
- R7: Elements outside the window of a load keep whatever character and flag they held before it.
- R8: A clear pulse sets every element flag to 0 in the next cycle. It also aborts a load in progress, so busy and in_ready go to 0, and it discards characters in flight so they are never stored.
- R9: A start with qlen = 0, or with base + qlen > N_ELEM, is ignored. So is a start while a load is busy; the running load keeps its placement.
- R10: No character ever travels past the last element of the chain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Erase all stored characters, in-flight characters and any active load |
| start | input | 1 | Begin a load with qlen and base |
| qlen | input | $clog2(N_ELEM+1) | Number of characters in the load |
| base | input | $clog2(N_ELEM) | Lowest element index of the load window |
| in_valid | input | 1 | Character stream valid |
| in_ready | output | 1 | Character stream ready |
| in_char | input | 5 | Character code |
| busy | output | 1 | A load is active |
| load_done | output | 1 | One-cycle pulse once every character of the load is stored |
| elem_vld | output | N_ELEM | Per-element "holds a query character" flags |
| elem_char | output | 5*N_ELEM | Stored characters; element i occupies bits [5i+4:5i] |

## Verification
The bench builds the block with N_ELEM = 8, so the chain is short enough to inspect every element after each load. This size brings into reach the full-length load, the largest hop count (7) and its exact arrival cycle at the last element, windows pressed against either end, and every window position in a randomised series of loads. The bench also checks stalls on the input stream, a character offered after the load is full, overlapping loads without a clear, a clear in the middle of a load, and illegal or overlapping start requests.

// File: rtl/ttlq_pkg.sv
package ttlq_pkg;
  localparam int CHAR_W = 5;
  typedef logic [CHAR_W-1:0] qchar_t;
  typedef enum logic {FD_IDLE = 1'b0, FD_LOAD = 1'b1} feed_state_e;
endpackage

// File: rtl/ttlq_feeder.sv
module ttlq_feeder
  import ttlq_pkg::*;
#(
  parameter int N_ELEM = 16,
  parameter int TTL_W  = 4,
  parameter int LEN_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             start,
  input  logic [LEN_W-1:0] qlen,
  input  logic [TTL_W-1:0] base,
  input  logic             in_valid,
  output logic             in_ready,
  input  qchar_t           in_char,
  input  logic             chain_busy,
  output logic             head_v,
  output qchar_t           head_ch,
  output logic [TTL_W-1:0] head_ttl,
  output logic             busy,
  output logic             load_done
);
  localparam int SUM_W = LEN_W + 1;

  feed_state_e      state;
  logic [LEN_W-1:0] remaining;
  logic [TTL_W-1:0] next_ttl;
  logic [SUM_W-1:0] span_end;
  logic             legal;
  logic             take;

  // Window end (exclusive) and legality of the requested window
  assign span_end = SUM_W'(base) + SUM_W'(qlen);
  assign legal    = (qlen != '0) && (span_end <= SUM_W'(N_ELEM));

  assign in_ready = (state == FD_LOAD) && (remaining != '0);
  assign take     = in_valid && in_ready;
  assign busy     = (state == FD_LOAD);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      state     <= FD_IDLE;
      remaining <= '0;
      next_ttl  <= '0;
      head_v    <= 1'b0;
      head_ch   <= '0;
      head_ttl  <= '0;
      load_done <= 1'b0;
    end else begin
      load_done <= 1'b0;
      head_v    <= take;
      if (take) begin
        head_ch   <= in_char;
        head_ttl  <= next_ttl;
        remaining <= remaining - 1'b1;
        next_ttl  <= next_ttl - 1'b1;
      end
      unique case (state)
        FD_IDLE: begin
          if (start && legal) begin
            state     <= FD_LOAD;
            remaining <= qlen;
            next_ttl  <= TTL_W'(span_end - 1'b1);
          end
        end
        FD_LOAD: begin
          // all characters issued and the chain fully drained
          if (remaining == '0 && !chain_busy) begin
            state     <= FD_IDLE;
            load_done <= 1'b1;
          end
        end
        default: state <= FD_IDLE;
      endcase
    end
  end

  // R4: an accepted character is launched at the chain head next cycle
  p_head_follows_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !clear) |=> (head_v && head_ch == $past(in_char)));

  // R6: the completion pulse lasts a single cycle
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> !load_done);

  // R9: an illegal request while idle leaves the loader idle
  p_illegal_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !legal && !clear) |=> !busy);
endmodule

// File: rtl/ttlq_cell.sv
module ttlq_cell
  import ttlq_pkg::*;
#(
  parameter int TTL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             in_v,
  input  qchar_t           in_ch,
  input  logic [TTL_W-1:0] in_ttl,
  output logic             out_v,
  output qchar_t           out_ch,
  output logic [TTL_W-1:0] out_ttl,
  output logic             held_v,
  output qchar_t           held_ch
);
  logic arrive_here;
  assign arrive_here = in_v && (in_ttl == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      out_v   <= 1'b0;
      out_ch  <= '0;
      out_ttl <= '0;
      held_v  <= 1'b0;
      held_ch <= '0;
    end else begin
      out_v   <= in_v && !arrive_here;
      out_ch  <= in_ch;
      out_ttl <= in_ttl - 1'b1;
      if (arrive_here) begin
        held_v  <= 1'b1;
        held_ch <= in_ch;
      end
    end
  end

  // R3: a character with zero hops left is kept by this element
  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_v && in_ttl == '0 && !clear) |=> (held_v && held_ch == $past(in_ch) && !out_v));

  // R5: a character with hops left moves one element per cycle, count reduced
  p_forward_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_v && in_ttl != '0 && !clear) |=> (out_v && out_ttl == $past(in_ttl) - 1'b1));
endmodule

// File: rtl/ttlq_distributor.sv
module ttlq_distributor
  import ttlq_pkg::*;
#(
  parameter int N_ELEM = 16,
  localparam int TTL_W = (N_ELEM > 1) ? $clog2(N_ELEM) : 1,
  localparam int LEN_W = $clog2(N_ELEM + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     start,
  input  logic [LEN_W-1:0]         qlen,
  input  logic [TTL_W-1:0]         base,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [CHAR_W-1:0]        in_char,
  output logic                     busy,
  output logic                     load_done,
  output logic [N_ELEM-1:0]        elem_vld,
  output logic [CHAR_W*N_ELEM-1:0] elem_char
);
  // link[i] feeds element i; link[N_ELEM] is the tail beyond the chain
  logic [N_ELEM:0] link_v;
  qchar_t          link_ch  [N_ELEM+1];
  logic [TTL_W-1:0] link_ttl [N_ELEM+1];
  logic            chain_busy;

  assign chain_busy = |link_v;

  ttlq_feeder #(.N_ELEM(N_ELEM), .TTL_W(TTL_W), .LEN_W(LEN_W)) feeder_i (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .start(start), .qlen(qlen), .base(base),
    .in_valid(in_valid), .in_ready(in_ready), .in_char(in_char),
    .chain_busy(chain_busy),
    .head_v(link_v[0]), .head_ch(link_ch[0]), .head_ttl(link_ttl[0]),
    .busy(busy), .load_done(load_done)
  );

  for (genvar gi = 0; gi < N_ELEM; gi++) begin : g_elem
    qchar_t held_ch;
    ttlq_cell #(.TTL_W(TTL_W)) cell_i (
      .clk(clk), .rst_n(rst_n), .clear(clear),
      .in_v(link_v[gi]), .in_ch(link_ch[gi]), .in_ttl(link_ttl[gi]),
      .out_v(link_v[gi+1]), .out_ch(link_ch[gi+1]), .out_ttl(link_ttl[gi+1]),
      .held_v(elem_vld[gi]), .held_ch(held_ch)
    );
    assign elem_char[gi*CHAR_W +: CHAR_W] = held_ch;
  end

  // R10: nothing ever leaves the far end of the chain
  p_no_overrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !link_v[N_ELEM]);

  // R8: clear empties every element and stops any load
  p_clear_wipes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (elem_vld == '0 && !busy && !chain_busy));

  // R6: completion comes only at the end of an active load
  p_done_ends_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> ($past(busy) && !busy && !chain_busy));
endmodule

// File: tb/ttlq_distributor_tb_top.sv
`timescale 1ns/1ps
module ttlq_distributor_tb_top;
  localparam int N  = 8;
  localparam int LW = $clog2(N + 1);
  localparam int TW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clear = 1'b0;
  logic          start = 1'b0;
  logic [LW-1:0] qlen = '0;
  logic [TW-1:0] base = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [4:0]    in_char = '0;
  logic          busy;
  logic          load_done;
  logic [N-1:0]  elem_vld;
  logic [5*N-1:0] elem_char;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;

  logic [4:0] exp_ch [N];
  logic       exp_v  [N];
  logic [4:0] q      [N];

  always #2 clk = ~clk;

  ttlq_distributor #(.N_ELEM(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .clear(clear), .start(start),
    .qlen(qlen), .base(base), .in_valid(in_valid), .in_ready(in_ready),
    .in_char(in_char), .busy(busy), .load_done(load_done),
    .elem_vld(elem_vld), .elem_char(elem_char)
  );

  task automatic chk(input string req, input int act, input int expv, input string what);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic check_elems(input string req);
    for (int i = 0; i < N; i++) begin
      chk(req, int'(elem_vld[i]), int'(exp_v[i]), $sformatf("flag[%0d]", i));
      if (exp_v[i])
        chk(req, int'(elem_char[i*5 +: 5]), int'(exp_ch[i]), $sformatf("char[%0d]", i));
    end
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    for (int i = 0; i < N; i++) exp_v[i] = 1'b0;
  endtask

  task automatic do_start(input int len, input int b);
    @(negedge clk); start = 1'b1; qlen = LW'(len); base = TW'(b);
    @(negedge clk); start = 1'b0;
  endtask

  // offer q[0..len-1] with 'gap' idle cycles between transfers
  task automatic feed(input int len, input int gap);
    for (int j = 0; j < len; j++) begin
      in_valid = 1'b1; in_char = q[j];
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!load_done && n < 100) begin @(negedge clk); n++; end
    chk(req, int'(load_done), 1, "load_done seen");
    chk(req, int'(busy), 0, "busy low with done");
    @(negedge clk);
    chk(req, int'(load_done), 0, "done is one cycle");
  endtask

  task automatic set_expected(input int len, input int b);
    for (int j = 0; j < len; j++) begin
      exp_v[b + len - 1 - j]  = 1'b1;
      exp_ch[b + len - 1 - j] = q[j];
    end
  endtask

  task automatic make_query(input int len);
    for (int j = 0; j < len; j++) q[j] = 5'($urandom_range(0, 31));
  endtask

  // R1
  task automatic t_reset();
    chk("R1", int'(elem_vld), 0, "flags after reset");
    chk("R1", int'(in_ready), 0, "in_ready after reset");
    chk("R1", int'(busy), 0, "busy after reset");
    chk("R1", int'(load_done), 0, "done after reset");
  endtask

  // R2 R3: full-length load, no gaps
  task automatic t_full();
    do_clear();
    make_query(N);
    do_start(N, 0);
    chk("R2", int'(busy), 1, "busy after start");
    chk("R2", int'(in_ready), 1, "ready after start");
    feed(N, 0);
    set_expected(N, 0);
    wait_done("R6");
    check_elems("R3");
  endtask

  // R3 R4: short query at the far end, stalls, extra offer after full
  task automatic t_far_end_stall();
    do_clear();
    make_query(3);
    do_start(3, N - 3);
    feed(3, 2);
    set_expected(3, N - 3);
    in_valid = 1'b1; in_char = 5'd31;
    @(negedge clk);
    chk("R4", int'(in_ready), 0, "ready low after qlen taken");
    wait_done("R6");
    chk("R4", int'(in_ready), 0, "ready low while extra offered");
    in_valid = 1'b0;
    check_elems("R4");
  endtask

  // R7: a smaller load over a full one leaves the rest untouched
  task automatic t_overlay();
    do_clear();
    make_query(N);
    do_start(N, 0);
    feed(N, 1);
    set_expected(N, 0);
    wait_done("R6");
    make_query(2);
    do_start(2, 2);
    feed(2, 0);
    set_expected(2, 2);
    wait_done("R6");
    check_elems("R7");
  endtask

  // R5: arrival cycle of a single character at element k
  task automatic t_timing(input int k);
    do_clear();
    q[0] = 5'd21;
    do_start(1, k);
    in_valid = 1'b1; in_char = q[0];
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < k; i++) @(negedge clk);
    chk("R5", int'(elem_vld[k]), 0, $sformatf("element %0d not yet", k));
    @(negedge clk);
    chk("R5", int'(elem_vld[k]), 1, $sformatf("element %0d arrived", k));
    chk("R5", int'(elem_char[k*5 +: 5]), 21, "arrived char");
    wait_done("R6");
  endtask

  // R9: illegal and overlapping starts
  task automatic t_illegal();
    do_clear();
    do_start(0, 0);
    chk("R9", int'(busy), 0, "qlen 0 ignored");
    chk("R9", int'(in_ready), 0, "qlen 0 no ready");
    do_start(N, 1);
    chk("R9", int'(busy), 0, "window past end ignored");
    make_query(2);
    do_start(2, 5);
    do_start(1, 0);
    feed(2, 0);
    set_expected(2, 5);
    wait_done("R6");
    check_elems("R9");
    chk("R9", int'(elem_vld[0]), 0, "start while busy ignored");
  endtask

  // R8: clear in the middle of a load
  task automatic t_clear_mid();
    do_clear();
    make_query(N);
    do_start(N, 0);
    feed(3, 0);
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    chk("R8", int'(busy), 0, "busy after clear");
    chk("R8", int'(in_ready), 0, "ready after clear");
    chk("R8", int'(elem_vld), 0, "flags after clear");
    repeat (N + 2) @(negedge clk);
    chk("R8", int'(elem_vld), 0, "no late stores after clear");
    chk("R8", int'(load_done), 0, "no done after clear");
  endtask

  // R3: random lengths and windows
  task automatic t_random(input int iters);
    for (int it = 0; it < iters; it++) begin
      int len = $urandom_range(1, N);
      int b   = $urandom_range(0, N - len);
      int gap = $urandom_range(0, 2);
      do_clear();
      make_query(len);
      do_start(len, b);
      feed(len, gap);
      set_expected(len, b);
      wait_done("R6");
      check_elems("R3");
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin exp_v[i] = 1'b0; exp_ch[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full();
    t_far_end_stall();
    t_overlay();
    t_timing(N - 1);
    t_timing(0);
    t_illegal();
    t_clear_mid();
    t_random(20);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule